// File: doc/BRIEF.md
# HDLC and Transparent Serial Frame Transmitter

This block takes frame bytes from a byte-wide transmit queue and turns them into a serial stream, one bit per clock. It has two modes. In HDLC mode it sends an opening flag, then every queued byte least significant bit first with zero insertion, then an optional CRC-16 that it computes itself, and then a closing flag. In transparent mode it first sends an all-ones synchronization byte. After that it passes queued bytes straight to the line, with no flags, no zero insertion and no checksum.

Software fills the queue and issues a one-cycle send command. The block pulls bytes through a valid/ready interface. It asserts `src_ready` for exactly one cycle at the end of each serialized segment. A byte moves only in a cycle where both `src_valid` and `src_ready` are high. The block does not wait for a late byte: if `src_valid` is low in the ready cycle, that counts as an underrun. A source with nothing to give must therefore keep `src_valid` low, and must hold `src_data` and `src_last` stable while `src_valid` is high. `src_last` marks the last byte of a frame. The block never checks how long a frame is.

When the checksum bypass is set, no CRC is appended. The last two queued bytes then act as the checksum that software supplies. Between frames the line idles at 1.

Top module: `hdlc_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_bit` is 1, `src_ready` is 0 and both interrupts are 0.
- R2: An HDLC frame is sent in this order: opening flag 0x7E, every queued byte least significant bit first, the checksum, then a closing flag 0x7E. After that the line returns to idle.
- R3: In HDLC mode, a 0 is inserted after every run of five consecutive 1s in the byte and CRC bits. No zero is inserted inside flags. A run that ends exactly at the end of a byte still gets its zero before the next segment.
- R4: With `crc_bypass` at 0, the CRC-16 is appended before the closing flag. It uses the reflected polynomial 0x8408 over the data bits, starts from 0xFFFF, and is sent ones-complemented with the low bit first. With `crc_bypass` at 1, no CRC is appended and the closing flag follows the last queued byte.
- R5: The frame length is not checked. A frame of a single byte is sent as a complete frame.
- R6: `pool_irq` is high for exactly one cycle, in the cycle after the byte marked `src_last` is accepted.
- R7: In HDLC mode, if `src_valid` is low when the next byte is needed, `under_irq` pulses once. The frame is then aborted with at least seven consecutive 1s and the line returns to idle.
- R8: Transparent mode is used only when `mode_code` is 3'b111 and `raw_en` is 1. Every other combination sends an HDLC frame. The mode and the bypass are latched at the send command.
- R9: In transparent mode, 0xFF is sent first and then the queued bytes, least significant bit first. There are no flags, no zero insertion and no CRC.
- R10: A transparent frame of one byte raises `pool_irq` and `under_irq` in the same cycle and blocks the transmitter. While blocked, `send_cmd` is ignored until `blk_clear` is pulsed.
- R11: `src_ready` is high for only one cycle at a time, and only while a frame is running. A frame accepts exactly as many bytes as it sends.
- R12: A `send_cmd` that arrives while a frame is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_code | input | 3 | Mode code; 3'b111 together with raw_en selects transparent mode |
| raw_en | input | 1 | Enables transparent mode when mode_code is 3'b111 |
| crc_bypass | input | 1 | 1: no internal CRC, software supplies the checksum bytes |
| send_cmd | input | 1 | One-cycle command that starts a frame |
| blk_clear | input | 1 | Releases the block left by a one-byte transparent frame |
| src_data | input | 8 | Byte from the transmit queue |
| src_valid | input | 1 | src_data and src_last are valid |
| src_ready | output | 1 | The block accepts a byte in this cycle |
| src_last | input | 1 | The byte offered is the last of the frame |
| tx_bit | output | 1 | Serial output, one bit per clock |
| pool_irq | output | 1 | One-cycle pulse after the last byte is taken |
| under_irq | output | 1 | One-cycle underrun pulse |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the one-cycle width of `src_ready` and of the pool-ready pulse, and that each interrupt follows its cause at the queue interface. They also check that the line sits at 1 while no frame is running, and that a send command has no effect while the block is blocked.

Other behaviours need the bench's directed scenarios, which compare the whole serial stream against a model built from the requirements. These are the bit order, the placement of inserted zeros, the CRC value, the abort pattern, the mode selection and the release of the block.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam logic [7:0]  FLAG_BYTE   = 8'h7E;
  localparam logic [7:0]  SYNC_BYTE   = 8'hFF;
  localparam logic [2:0]  RAW_CODE    = 3'b111;
  localparam logic [15:0] CRC_POLY_RF = 16'h8408;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;

  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_OPEN,
    SEG_DATA,
    SEG_CRC,
    SEG_CLOSE,
    SEG_ABORT,
    SEG_SYNC,
    SEG_RAW
  } seg_e;
endpackage

// File: rtl/hdlc_crc_serial.sv
module hdlc_crc_serial #(
  parameter int          CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h8408,
  parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             shift_en,
  input  logic             din,
  output logic [CRC_W-1:0] crc_next
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  // reflected update: one data bit per clock, low bit first
  always_comb begin
    fb       = crc_q[0] ^ din;
    crc_next = (crc_q >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        crc_q <= INIT;
    else if (restart)  crc_q <= INIT;
    else if (shift_en) crc_q <= crc_next;
  end
endmodule

// File: rtl/hdlc_zero_stuffer.sv
module hdlc_zero_stuffer #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic bit_sent,
  input  logic bit_val,
  input  logic countable,
  output logic insert
);
  localparam int OW = $clog2(RUN + 1);
  logic [OW-1:0] ones_q;

  assign insert = (ones_q == OW'(RUN));

  always_ff @(posedge clk) begin
    if (!rst_n)        ones_q <= '0;
    else if (restart)  ones_q <= '0;
    else if (insert)   ones_q <= '0;
    else if (bit_sent) ones_q <= (countable && bit_val) ? ones_q + 1'b1 : '0;
  end
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int CRC_W     = 16,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_code,
  input  logic              raw_en,
  input  logic              crc_bypass,
  input  logic              send_cmd,
  input  logic              blk_clear,
  input  logic [BYTE_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic              src_last,
  output logic              tx_bit,
  output logic              pool_irq,
  output logic              under_irq
);
  localparam int SH_W  = (CRC_W > BYTE_W) ? CRC_W : BYTE_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  seg_e             seg_q, seg_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_q, raw_q, byp_q, blocked_q;
  logic             tx_q, pool_q, under_q;

  logic             busy_w, insert_w, emit_w, seg_end_w, stuffable_w;
  logic             need_byte_w, take_w, starve_w, start_w, raw_sel_w, lone_raw_w;
  logic [CRC_W-1:0] crc_next_w;

  assign raw_sel_w   = (mode_code == RAW_CODE) && raw_en;
  assign busy_w      = (seg_q != SEG_IDLE);
  assign start_w     = !busy_w && send_cmd && !blocked_q;
  assign emit_w      = busy_w && !insert_w;
  assign seg_end_w   = emit_w && (cnt_q == CNT_W'(1));
  assign stuffable_w = (seg_q == SEG_DATA) || (seg_q == SEG_CRC);

  always_comb begin
    need_byte_w = 1'b0;
    if (seg_end_w) begin
      unique case (seg_q)
        SEG_OPEN, SEG_SYNC: need_byte_w = 1'b1;
        SEG_DATA, SEG_RAW:  need_byte_w = !last_q;
        default:            need_byte_w = 1'b0;
      endcase
    end
  end

  assign src_ready  = need_byte_w;
  assign take_w     = need_byte_w && src_valid;
  assign starve_w   = need_byte_w && !src_valid;
  assign lone_raw_w = take_w && src_last && raw_q && (seg_q == SEG_SYNC);

  hdlc_crc_serial #(
    .CRC_W (CRC_W),
    .POLY  (CRC_W'(CRC_POLY_RF)),
    .INIT  (CRC_W'(CRC_PRESET))
  ) crc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start_w),
    .shift_en (emit_w && (seg_q == SEG_DATA)),
    .din      (sh_q[0]),
    .crc_next (crc_next_w)
  );

  hdlc_zero_stuffer #(.RUN(STUFF_RUN)) stuff_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start_w),
    .bit_sent  (emit_w),
    .bit_val   (sh_q[0]),
    .countable (stuffable_w),
    .insert    (insert_w)
  );

  // segment sequencing
  always_comb begin
    seg_d = seg_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (start_w) begin
      seg_d = raw_sel_w ? SEG_SYNC : SEG_OPEN;
      sh_d  = SH_W'(raw_sel_w ? SYNC_BYTE : FLAG_BYTE);
      cnt_d = CNT_W'(BYTE_W);
    end else if (emit_w) begin
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q - 1'b1;
      if (seg_end_w) begin
        unique case (seg_q)
          SEG_OPEN, SEG_SYNC, SEG_DATA, SEG_RAW: begin
            if ((seg_q == SEG_DATA) && last_q) begin
              if (byp_q) begin
                seg_d = SEG_CLOSE;
                sh_d  = SH_W'(FLAG_BYTE);
                cnt_d = CNT_W'(BYTE_W);
              end else begin
                seg_d = SEG_CRC;
                sh_d  = SH_W'(~crc_next_w);
                cnt_d = CNT_W'(CRC_W);
              end
            end else if ((seg_q == SEG_RAW) && last_q) begin
              seg_d = SEG_IDLE;
            end else if (take_w) begin
              seg_d = raw_q ? SEG_RAW : SEG_DATA;
              sh_d  = SH_W'(src_data);
              cnt_d = CNT_W'(BYTE_W);
            end else if (raw_q) begin
              seg_d = SEG_IDLE;
            end else begin
              seg_d = SEG_ABORT;
              sh_d  = {SH_W{1'b1}};
              cnt_d = CNT_W'(ABORT_LEN);
            end
          end
          SEG_CRC: begin
            seg_d = SEG_CLOSE;
            sh_d  = SH_W'(FLAG_BYTE);
            cnt_d = CNT_W'(BYTE_W);
          end
          default: seg_d = SEG_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q     <= SEG_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      last_q    <= 1'b0;
      raw_q     <= 1'b0;
      byp_q     <= 1'b0;
      blocked_q <= 1'b0;
      tx_q      <= 1'b1;
      pool_q    <= 1'b0;
      under_q   <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      tx_q    <= busy_w ? (insert_w ? 1'b0 : sh_q[0]) : 1'b1;
      pool_q  <= take_w && src_last;
      under_q <= starve_w || lone_raw_w;
      if (start_w) begin
        last_q <= 1'b0;
        raw_q  <= raw_sel_w;
        byp_q  <= crc_bypass;
      end else if (take_w) begin
        last_q <= src_last;
      end
      if (lone_raw_w)     blocked_q <= 1'b1;
      else if (blk_clear) blocked_q <= 1'b0;
    end
  end

  assign tx_bit    = tx_q;
  assign pool_irq  = pool_q;
  assign under_irq = under_q;
endmodule

// File: rtl/hdlc_frame_tx_chk.sv
module hdlc_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic send_cmd,
  input logic src_valid,
  input logic src_ready,
  input logic src_last,
  input logic tx_bit,
  input logic pool_irq,
  input logic under_irq,
  input logic busy,
  input logic blocked
);
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> tx_bit);

  assert_idle_no_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> busy);

  assert_ready_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |=> !src_ready);

  assert_pool_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pool_irq |-> $past(src_valid && src_ready && src_last));

  assert_pool_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pool_irq |=> !pool_irq);

  assert_under_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    under_irq |-> $past(src_ready && (!src_valid || src_last)));

  assert_blocked_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !busy && send_cmd) |=> !busy);
endmodule

bind hdlc_frame_tx hdlc_frame_tx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .send_cmd  (send_cmd),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .src_last  (src_last),
  .tx_bit    (tx_bit),
  .pool_irq  (pool_irq),
  .under_irq (under_irq),
  .busy      (busy_w),
  .blocked   (blocked_q)
);

// File: tb/hdlc_frame_tx_tb_top.sv
`timescale 1ns/1ps
module hdlc_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_code = 3'b000;
  logic       raw_en = 1'b0;
  logic       crc_bypass = 1'b0;
  logic       send_cmd = 1'b0;
  logic       blk_clear = 1'b0;
  logic [7:0] src_data;
  logic       src_valid, src_ready, src_last;
  logic       tx_bit, pool_irq, under_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // queue model
  logic [7:0] fdata [0:15];
  logic       flast [0:15];
  int         fn = 0;
  int         fidx = 0;
  logic       fifo_rst = 1'b0;
  int         pool_cnt = 0, under_cnt = 0, pop_cnt = 0;
  logic       cnt_rst = 1'b0;

  // expected bit stream
  logic expb [0:1023];
  int   en = 0;
  int   ones = 0;
  logic [15:0] crc_m;

  always #2 clk = ~clk;

  assign src_valid = (fidx < fn);
  assign src_data  = (fidx < fn) ? fdata[fidx] : 8'h00;
  assign src_last  = (fidx < fn) ? flast[fidx] : 1'b0;

  always @(posedge clk) begin
    if (fifo_rst) fidx <= 0;
    else if (src_valid && src_ready) fidx <= fidx + 1;
  end

  always @(posedge clk) begin
    if (cnt_rst) begin
      pool_cnt <= 0; under_cnt <= 0; pop_cnt <= 0;
    end else begin
      if (pool_irq) pool_cnt <= pool_cnt + 1;
      if (under_irq) under_cnt <= under_cnt + 1;
      if (src_valid && src_ready) pop_cnt <= pop_cnt + 1;
    end
  end

  hdlc_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .raw_en(raw_en),
    .crc_bypass(crc_bypass), .send_cmd(send_cmd), .blk_clear(blk_clear),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .src_last(src_last), .tx_bit(tx_bit), .pool_irq(pool_irq), .under_irq(under_irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_bit(input logic b, input bit stuff);
    expb[en] = b; en++;
    if (stuff) begin
      ones = b ? ones + 1 : 0;
      if (ones == 5) begin expb[en] = 1'b0; en++; ones = 0; end
    end else ones = 0;
  endtask

  task automatic push_byte(input logic [7:0] b, input bit stuff, input bit crc_on);
    for (int i = 0; i < 8; i++) begin
      if (crc_on) crc_m = (crc_m >> 1) ^ ((crc_m[0] ^ b[i]) ? 16'h8408 : 16'h0000);
      push_bit(b[i], stuff);
    end
  endtask

  // build the expected stream from the loaded queue
  task automatic build_hdlc(input bit with_crc, input bit aborted);
    en = 0; ones = 0; crc_m = 16'hFFFF;
    push_byte(8'h7E, 1'b0, 1'b0);
    for (int i = 0; i < fn; i++) push_byte(fdata[i], 1'b1, 1'b1);
    if (!aborted) begin
      if (with_crc) begin
        crc_m = ~crc_m;
        push_byte(crc_m[7:0], 1'b1, 1'b0);
        push_byte(crc_m[15:8], 1'b1, 1'b0);
      end
      push_byte(8'h7E, 1'b0, 1'b0);
    end
  endtask

  task automatic build_raw();
    en = 0; ones = 0;
    push_byte(8'hFF, 1'b0, 1'b0);
    for (int i = 0; i < fn; i++) push_byte(fdata[i], 1'b0, 1'b0);
  endtask

  task automatic load(input int n, input bit mark_last, input logic [7:0] b0,
                      input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    @(negedge clk);
    fdata[0] = b0; fdata[1] = b1; fdata[2] = b2; fdata[3] = b3;
    for (int i = 0; i < 16; i++) flast[i] = 1'b0;
    if (mark_last && n > 0) flast[n-1] = 1'b1;
    fn = n;
    fifo_rst = 1'b1; cnt_rst = 1'b1;
    @(negedge clk);
    fifo_rst = 1'b0; cnt_rst = 1'b0;
  endtask

  // issue the command and compare the serial stream; optional second command mid-frame
  task automatic send_and_compare(input string req, input bit again);
    int first_bad;
    logic got;
    first_bad = -1;
    send_cmd = 1'b1;
    @(negedge clk);
    send_cmd = 1'b0;
    for (int i = 0; i < en + 24; i++) begin
      @(posedge clk);
      @(negedge clk);
      got = tx_bit;
      if (first_bad < 0 && got !== ((i < en) ? expb[i] : 1'b1)) first_bad = i;
      if (again && i == 20) send_cmd = 1'b1;
      if (again && i == 21) send_cmd = 1'b0;
    end
    check(first_bad < 0, req, "stream first mismatching bit index", first_bad, -1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(tx_bit === 1'b1, "R1", "tx idle", tx_bit, 1);
    check(src_ready === 1'b0, "R1", "ready idle", src_ready, 0);
    check(pool_irq === 1'b0 && under_irq === 1'b0, "R1", "irqs idle",
          pool_irq + under_irq, 0);
  endtask

  task automatic t_hdlc_crc();
    mode_code = 3'b000; raw_en = 1'b0; crc_bypass = 1'b0;
    load(4, 1'b1, 8'hFF, 8'h03, 8'hF8, 8'h7E);
    build_hdlc(1'b1, 1'b0);
    send_and_compare("R2 R3 R4 R12", 1'b1);
    check(pool_cnt == 1, "R6", "pool pulses", pool_cnt, 1);
    check(under_cnt == 0, "R7", "no underrun", under_cnt, 0);
    check(pop_cnt == 4, "R11", "bytes accepted", pop_cnt, 4);
  endtask

  task automatic t_hdlc_bypass();
    crc_bypass = 1'b1;
    load(4, 1'b1, 8'h01, 8'h3F, 8'hAB, 8'hCD);
    build_hdlc(1'b0, 1'b0);
    send_and_compare("R4 bypass", 1'b0);
    check(pool_cnt == 1, "R6", "pool pulses bypass", pool_cnt, 1);
    crc_bypass = 1'b0;
  endtask

  task automatic t_one_byte_hdlc();
    load(1, 1'b1, 8'h1F, 8'h00, 8'h00, 8'h00);
    build_hdlc(1'b1, 1'b0);
    send_and_compare("R5", 1'b0);
    check(pool_cnt == 1 && under_cnt == 0, "R5", "irq counts one byte",
          pool_cnt * 10 + under_cnt, 10);
  endtask

  task automatic t_underrun();
    load(2, 1'b0, 8'h12, 8'h34, 8'h00, 8'h00);
    build_hdlc(1'b0, 1'b1);
    send_and_compare("R7", 1'b0);
    check(under_cnt == 1, "R7", "underrun pulses", under_cnt, 1);
    check(pool_cnt == 0, "R7", "no pool on abort", pool_cnt, 0);
  endtask

  task automatic t_mode_select();
    mode_code = 3'b111; raw_en = 1'b0;
    load(2, 1'b1, 8'h55, 8'hAA, 8'h00, 8'h00);
    build_hdlc(1'b1, 1'b0);
    send_and_compare("R8 code only", 1'b0);
    mode_code = 3'b011; raw_en = 1'b1;
    load(2, 1'b1, 8'h0F, 8'hF0, 8'h00, 8'h00);
    build_hdlc(1'b1, 1'b0);
    send_and_compare("R8 enable only", 1'b0);
  endtask

  task automatic t_raw();
    mode_code = 3'b111; raw_en = 1'b1;
    load(3, 1'b1, 8'hFF, 8'h7E, 8'h81, 8'h00);
    build_raw();
    send_and_compare("R9", 1'b0);
    check(pool_cnt == 1 && under_cnt == 0, "R9", "irq counts raw",
          pool_cnt * 10 + under_cnt, 10);
    check(pop_cnt == 3, "R11", "raw bytes accepted", pop_cnt, 3);
  endtask

  task automatic t_raw_one();
    mode_code = 3'b111; raw_en = 1'b1;
    load(1, 1'b1, 8'hC3, 8'h00, 8'h00, 8'h00);
    build_raw();
    send_and_compare("R10", 1'b0);
    check(pool_cnt == 1 && under_cnt == 1, "R10", "both irqs",
          pool_cnt * 10 + under_cnt, 11);
    // blocked: a new command must leave the line idle and take no byte
    load(1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00);
    en = 0;
    send_and_compare("R10 blocked", 1'b0);
    check(pop_cnt == 0, "R10", "no byte while blocked", pop_cnt, 0);
    @(negedge clk); blk_clear = 1'b1;
    @(negedge clk); blk_clear = 1'b0;
    mode_code = 3'b000; raw_en = 1'b0;
    load(1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00);
    build_hdlc(1'b1, 1'b0);
    send_and_compare("R10 released", 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hdlc_crc();
    t_hdlc_bypass();
    t_one_byte_hdlc();
    t_underrun();
    t_mode_select();
    t_raw();
    t_raw_one();
    t_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule